// File: doc/BRIEF.md
# Fetch Target Predictor Table

This block is a small direct-mapped table that the instruction fetch stage consults every cycle to decide where to fetch next. The current fetch address is looked up combinationally: part of the word address selects one slot, and the rest of the address is compared with the identifier stored in that slot. When the slot is occupied and the identifiers agree, the block reports a hit along with the stored destination address and a stored direction bit. Fetch moves to the stored destination only when that bit says the branch goes; otherwise it moves to the next sequential word.

When the execute stage learns how a branch actually went, it reports this through the update port. A branch that went writes its identifier and destination into its slot and marks the slot as predicting "go". Any earlier occupant of that slot is replaced. A branch that did not go only clears the direction bit of a slot it already owns, and never claims a slot. Updates take effect at the next clock edge. The slot count is set by a parameter.

Top module: `btb_core`

## Requirements
- R1: While reset is asserted, and on the first cycle after the internal reset releases, every lookup misses (`hit`=0, `pred_taken`=0), because all occupancy bits are cleared.
- R2: `hit` is 1 only when the slot selected by `fetch_pc` is occupied and its stored identifier equals `fetch_pc[PC_W-1:IDX_W+2]`. On a hit `pred_target` is that slot's stored destination. `pred_taken` is 1 only on a hit.
- R3: On a miss, `next_pc` equals `fetch_pc + 4` and `pred_taken` is 0.
- R4: On a hit whose direction bit says "go", `pred_taken` is 1 and `next_pc` equals `pred_target`.
- R5: On a hit whose direction bit says "not go", `pred_taken` is 0 and `next_pc` equals `fetch_pc + 4`.
- R6: An update with `upd_taken`=1 is not visible to a lookup in the same cycle. From the next cycle on, a lookup of `upd_pc` hits with `pred_taken`=1 and target `upd_target`.
- R7: A taken update to a slot held by a different identifier replaces that slot. The old address then misses.
- R8: A not-taken update to an address that currently hits clears the direction bit and keeps the slot occupied with its target unchanged.
- R9: A not-taken update to an address that misses changes nothing. That address still misses, and the current occupant of its slot keeps its target and direction.
- R10: The slot index is `pc[IDX_W+1:2]`. Bits `pc[1:0]` take part in neither the index nor the identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| hit | output | 1 | Occupied slot with matching identifier |
| pred_taken | output | 1 | Hit whose stored direction says "go" |
| pred_target | output | PC_W | Stored destination of the selected slot |
| next_pc | output | PC_W | Address to fetch next |
| upd_en | input | 1 | Update strobe |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_target | input | PC_W | Resolved destination |
| upd_taken | input | 1 | Resolved direction, 1 = went |

## Verification
Lookup outputs are combinational, so every expected lookup result is due in the same cycle the fetch address is driven, and it reflects the table as it stood before that cycle's edge. An update is due one edge later. The driver applies inputs on the falling edge and queues the expected result for that cycle. The monitor compares a quarter period later, before the next rising edge. Checks of an update therefore always look at the step after the one that carried it. The internal reset release takes two edges, and the bench waits three cycles before the first lookup after reset.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int unsigned INSN_BYTES = 4;

  typedef enum logic {
    SEL_SEQ = 1'b0,
    SEL_TGT = 1'b1
  } fetch_sel_e;
endpackage

// File: rtl/btb_rst_sync.sv
module btb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/btb_match.sv
module btb_match #(
  parameter int unsigned TAG_W = 26
) (
  input  logic             slot_valid,
  input  logic [TAG_W-1:0] slot_tag,
  input  logic [TAG_W-1:0] probe_tag,
  output logic             match
);
  assign match = slot_valid && (slot_tag == probe_tag);
endmodule

// File: rtl/btb_store.sv
module btb_store #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned TAG_W = 26,
  localparam int unsigned SLOTS = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_tgt,
  input  logic [IDX_W-1:0] f_idx,
  output logic             f_valid,
  output logic [TAG_W-1:0] f_tag,
  output logic [PC_W-1:0]  f_tgt,
  output logic             f_go,
  input  logic [IDX_W-1:0] u_idx,
  output logic             u_valid,
  output logic [TAG_W-1:0] u_tag
);
  logic [SLOTS-1:0] valid_a;
  logic [SLOTS-1:0] go_a;
  logic [TAG_W-1:0] tag_a [SLOTS];
  logic [PC_W-1:0]  tgt_a [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic             sel;
    logic             v_q, v_d;
    logic             g_q, g_d;
    logic [TAG_W-1:0] tag_q;
    logic [PC_W-1:0]  tgt_q;

    assign sel = (wr_idx == IDX_W'(s));

    always_comb begin
      v_d = v_q;
      g_d = g_q;
      if (sel && alloc_en) begin
        v_d = 1'b1;
        g_d = 1'b1;
      end else if (sel && clr_en) begin
        g_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        g_q <= 1'b0;
      end else begin
        v_q <= v_d;
        g_q <= g_d;
      end
    end

    always_ff @(posedge clk) begin
      if (sel && alloc_en) begin
        tag_q <= wr_tag;
        tgt_q <= wr_tgt;
      end
    end

    assign valid_a[s] = v_q;
    assign go_a[s]    = g_q;
    assign tag_a[s]   = tag_q;
    assign tgt_a[s]   = tgt_q;
  end

  assign f_valid = valid_a[f_idx];
  assign f_tag   = tag_a[f_idx];
  assign f_tgt   = tgt_a[f_idx];
  assign f_go    = go_a[f_idx];
  assign u_valid = valid_a[u_idx];
  assign u_tag   = tag_a[u_idx];
endmodule

// File: rtl/btb_core.sv
module btb_core #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            hit,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_target,
  output logic [PC_W-1:0] next_pc,
  input  logic            upd_en,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_taken
);
  import btb_pkg::*;

  localparam int unsigned IDX_LSB = 2;
  localparam int unsigned TAG_LSB = IDX_W + IDX_LSB;
  localparam int unsigned TAG_W   = PC_W - TAG_LSB;

  logic             rst_sync_n;
  logic [IDX_W-1:0] f_idx, u_idx;
  logic [TAG_W-1:0] f_probe, u_probe;
  logic             f_valid, u_valid, f_go;
  logic [TAG_W-1:0] f_tag, u_tag;
  logic [PC_W-1:0]  f_tgt;
  logic             f_match, u_match;
  logic             alloc_en, clr_en;
  fetch_sel_e       sel;
  logic             unused_upd_low;

  assign f_idx   = fetch_pc[TAG_LSB-1:IDX_LSB];
  assign f_probe = fetch_pc[PC_W-1:TAG_LSB];
  assign u_idx   = upd_pc[TAG_LSB-1:IDX_LSB];
  assign u_probe = upd_pc[PC_W-1:TAG_LSB];
  assign unused_upd_low = ^upd_pc[IDX_LSB-1:0];

  btb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  btb_store #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .alloc_en (alloc_en),
    .clr_en   (clr_en),
    .wr_idx   (u_idx),
    .wr_tag   (u_probe),
    .wr_tgt   (upd_target),
    .f_idx    (f_idx),
    .f_valid  (f_valid),
    .f_tag    (f_tag),
    .f_tgt    (f_tgt),
    .f_go     (f_go),
    .u_idx    (u_idx),
    .u_valid  (u_valid),
    .u_tag    (u_tag)
  );

  btb_match #(.TAG_W(TAG_W)) u_fmatch (
    .slot_valid (f_valid),
    .slot_tag   (f_tag),
    .probe_tag  (f_probe),
    .match      (f_match)
  );

  btb_match #(.TAG_W(TAG_W)) u_umatch (
    .slot_valid (u_valid),
    .slot_tag   (u_tag),
    .probe_tag  (u_probe),
    .match      (u_match)
  );

  always_comb begin
    alloc_en = upd_en && upd_taken;
    clr_en   = upd_en && !upd_taken && u_match;
  end

  always_comb begin
    sel = (f_match && f_go) ? SEL_TGT : SEL_SEQ;
    unique case (sel)
      SEL_TGT: next_pc = f_tgt;
      default: next_pc = fetch_pc + PC_W'(INSN_BYTES);
    endcase
  end

  assign hit         = f_match;
  assign pred_taken  = (sel == SEL_TGT);
  assign pred_target = f_tgt;
endmodule

// File: rtl/btb_core_chk.sv
module btb_core_chk #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk,
  input logic            rst_q,
  input logic [PC_W-1:0] fetch_pc,
  input logic            hit,
  input logic            pred_taken,
  input logic [PC_W-1:0] pred_target,
  input logic [PC_W-1:0] next_pc,
  input logic            upd_en,
  input logic [PC_W-1:0] upd_pc,
  input logic [PC_W-1:0] upd_target,
  input logic            upd_taken
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(rst_q) |-> !hit && !pred_taken);

  p_go_needs_hit_r2: assert property (@(posedge clk) disable iff (!rst_q)
    pred_taken |-> hit);

  p_miss_seq_r3: assert property (@(posedge clk) disable iff (!rst_q)
    !hit |-> next_pc == fetch_pc + PC_W'(4));

  p_go_redirect_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (hit && pred_taken) |-> next_pc == pred_target);

  p_stay_seq_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (hit && !pred_taken) |-> next_pc == fetch_pc + PC_W'(4));

  p_alloc_next_r6: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(rst_q) && $past(upd_en && upd_taken) && fetch_pc == $past(upd_pc))
      |-> hit && pred_taken && pred_target == $past(upd_target));

  p_clear_go_r8: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(rst_q) && $past(upd_en && !upd_taken) && fetch_pc == $past(upd_pc))
      |-> !pred_taken);
endmodule

bind btb_core btb_core_chk #(.PC_W(PC_W)) u_chk (
  .clk         (clk),
  .rst_q       (rst_sync_n),
  .fetch_pc    (fetch_pc),
  .hit         (hit),
  .pred_taken  (pred_taken),
  .pred_target (pred_target),
  .next_pc     (next_pc),
  .upd_en      (upd_en),
  .upd_pc      (upd_pc),
  .upd_target  (upd_target),
  .upd_taken   (upd_taken)
);

// File: tb/sim_btb_core.sv
module sim_btb_core;
  logic        clk;
  logic        rst_n;
  logic [31:0] fetch_pc;
  logic        hit, pred_taken;
  logic [31:0] pred_target, next_pc;
  logic        upd_en;
  logic [31:0] upd_pc, upd_target;
  logic        upd_taken;

  typedef struct {
    string       req;
    logic [31:0] pc;
    bit          hit;
    bit          tk;
    logic [31:0] tgt;
    logic [31:0] nxt;
  } exp_t;

  exp_t q[$];
  int   errors = 0;
  int   checks = 0;
  bit   done   = 0;

  btb_core #(.PC_W(32), .IDX_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .hit(hit),
    .pred_taken(pred_taken), .pred_target(pred_target), .next_pc(next_pc),
    .upd_en(upd_en), .upd_pc(upd_pc), .upd_target(upd_target),
    .upd_taken(upd_taken)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic cmp(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] pc, input bit ue,
                      input logic [31:0] upc, input logic [31:0] utgt,
                      input bit utk, input bit eh, input bit etk,
                      input logic [31:0] etgt, input string req);
    exp_t it;
    @(negedge clk);
    fetch_pc   = pc;
    upd_en     = ue;
    upd_pc     = upc;
    upd_target = utgt;
    upd_taken  = utk;
    it.req = req; it.pc = pc; it.hit = eh; it.tk = etk; it.tgt = etgt;
    it.nxt = (eh && etk) ? etgt : pc + 32'd4;
    q.push_back(it);
  endtask

  task automatic look(input logic [31:0] pc, input bit eh, input bit etk,
                      input logic [31:0] etgt, input string req);
    step(pc, 1'b0, 32'h0, 32'h0, 1'b0, eh, etk, etgt, req);
  endtask

  initial begin : monitor
    exp_t it;
    forever begin
      @(negedge clk);
      #5;
      while (q.size() > 0) begin
        it = q.pop_front();
        cmp(it.req, "hit", {31'b0, hit}, {31'b0, it.hit});
        cmp(it.req, "pred_taken", {31'b0, pred_taken}, {31'b0, it.tk});
        cmp(it.req, "next_pc", next_pc, it.nxt);
        if (it.hit) cmp(it.req, "pred_target", pred_target, it.tgt);
      end
    end
  end

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  localparam logic [31:0] A  = 32'h0000_1004;
  localparam logic [31:0] B  = 32'h0000_1044;
  localparam logic [31:0] C  = 32'h0000_1008;

  initial begin : driver
    rst_n = 1'b0; fetch_pc = A; upd_en = 1'b0;
    upd_pc = '0; upd_target = '0; upd_taken = 1'b0;
    // R1: lookup while reset is held
    look(A, 1'b0, 1'b0, 32'h0, "R1");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    look(A, 1'b0, 1'b0, 32'h0, "R1");
    // R6: taken update invisible in its own cycle
    step(A, 1'b1, A, 32'h0000_2000, 1'b1, 1'b0, 1'b0, 32'h0, "R6");
    look(A, 1'b1, 1'b1, 32'h0000_2000, "R6_R4");
    // R10: low two bits ignored
    look(32'h0000_1006, 1'b1, 1'b1, 32'h0000_2000, "R10");
    // R3: other slot misses
    look(C, 1'b0, 1'b0, 32'h0, "R3");
    // R8: not-taken update on a hitting entry
    step(A, 1'b1, A, 32'h0000_9999, 1'b0, 1'b1, 1'b1, 32'h0000_2000, "R8");
    look(A, 1'b1, 1'b0, 32'h0000_2000, "R8_R5");
    // R2: same slot, different identifier misses
    step(B, 1'b1, B, 32'h0000_7000, 1'b0, 1'b0, 1'b0, 32'h0, "R2");
    // R9: not-taken miss does not allocate or disturb occupant
    look(B, 1'b0, 1'b0, 32'h0, "R9");
    look(A, 1'b1, 1'b0, 32'h0000_2000, "R9");
    // R7: taken update replaces a different occupant
    step(A, 1'b1, B, 32'h0000_3000, 1'b1, 1'b1, 1'b0, 32'h0000_2000, "R7");
    look(B, 1'b1, 1'b1, 32'h0000_3000, "R7");
    look(A, 1'b0, 1'b0, 32'h0, "R7");
    // R6: re-allocation with a new destination
    step(C, 1'b1, A, 32'h0000_2400, 1'b1, 1'b0, 1'b0, 32'h0, "R6");
    look(A, 1'b1, 1'b1, 32'h0000_2400, "R6");
    look(B, 1'b0, 1'b0, 32'h0, "R7");
    // R1: mid-run reset clears occupancy
    @(negedge clk); rst_n = 1'b0;
    look(A, 1'b0, 1'b0, 32'h0, "R1");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    look(A, 1'b0, 1'b0, 32'h0, "R1");
    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule